// File: doc/BRIEF.md
# Card Host Interrupt and Clock Control Unit

This unit is the interrupt and clock front end of a memory-card host controller. It keeps a 13-bit interrupt request register and a matching mask register. From them it drives one registered CPU interrupt line and two registered DMA request lines, one for receive and one for transmit. Request bits are set and cleared by event pulses from the FIFO and command logic. The clock-off request bit is owned by the clock commands.

Clock start and stop commands arrive as a write strobe with two command bits. A write to the command configuration queues a command. The command launches at once if the card clock is already running and the stop-transfer flag is clear. Otherwise it waits, and a later clock start launches it, provided the stored stop-transfer flag is clear. A launch shows as a one-cycle pulse to the command sequencer and marks a transfer active. A stop-clock command aborts the active transfer. When DMA is enabled, the two FIFO request bits are removed from the CPU interrupt and go to the DMA lines instead.

Top module: `cardhost_irqclk`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: every request bit, every mask bit, every status bit, the pending flag, the active flag, the launch pulse, the interrupt line and both DMA lines.
- R2: A mask write stores the low 13 bits of the write data. Higher data bits are discarded.
- R3: The interrupt line is high exactly when some request bit is set whose mask bit is clear. It follows a change to the request or mask register one cycle after that register updates.
- R4: While DMA is enabled, request bits 5 (receive FIFO) and 6 (transmit FIFO) are left out of the interrupt, and they drive the receive and transmit DMA lines. While DMA is disabled, both DMA lines are low. A change of DMA enable takes effect on the next clock edge.
- R5: A clock command with bit 1 (start) set and bit 0 clear sets status bit 8 (clock enabled) and clears request bit 4 (clock off).
- R6: A clock command with bit 0 (stop) set clears status bit 8, sets request bit 4 and clears the active flag. Stop takes priority over a start in the same write: no launch occurs and a pending command stays pending.
- R7: A configuration write with stop-transfer set marks a command pending, clears the active flag, leaves the status bits unchanged and does not launch.
- R8: A configuration write with stop-transfer clear marks a command pending and clears every status bit except bit 8. It launches at once if the clock is enabled; otherwise the command stays pending.
- R9: A start command launches a pending command only if the stop-transfer flag stored by the last configuration write is clear. A launch clears pending, sets active and clears every status bit except bit 8. If that flag is set, the command stays pending and does not launch.
- R10: A launch shows on the launch output for exactly one cycle. A transfer-done pulse clears the active flag.
- R11: For an event-driven request bit, a set pulse wins over a clear pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clkCmdWe | input | 1 | Clock command write strobe |
| clkCmdData | input | 2 | Bit 0 stop clock, bit 1 start clock |
| cfgWe | input | 1 | Command configuration write strobe |
| cfgStopTran | input | 1 | Stop-transfer flag of the configuration write |
| dmaEn | input | 1 | DMA enable configuration level |
| maskWe | input | 1 | Mask write strobe |
| maskData | input | WR_W | Mask write data |
| evtSet | input | REQ_W | Request set pulses from FIFO and command logic |
| evtClr | input | REQ_W | Request clear pulses |
| statEvt | input | STAT_W | Status set pulses (bit 8 ignored) |
| xferDone | input | 1 | Transfer finished pulse |
| irq | output | 1 | CPU interrupt line |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| launch | output | 1 | One-cycle command launch pulse |
| cmdPending | output | 1 | Command queued, not launched |
| xferActive | output | 1 | Transfer in progress |
| reqBits | output | REQ_W | Interrupt request register |
| maskBits | output | REQ_W | Interrupt mask register |
| status | output | STAT_W | Status, bit 8 is clock enabled |

## Verification
Register-level results are due one cycle after the strobe that causes them: request, mask, status, pending, active and launch all update on the edge that samples the strobe. The interrupt and DMA lines are one register further on. They are due two cycles after a request or mask strobe, and one cycle after a change of DMA enable. The launch pulse is also checked to be low again in the second cycle. Each stimulus task files its expectations with the absolute cycle in which they are due. A monitor compares them on the falling edge of that cycle, so every output is read only when it is stable.

// File: rtl/cardhost_irqclk_pkg.sv
package cardhost_irqclk_pkg;
  // Request bit positions decoded by the clock and DMA logic
  localparam int unsigned CLKOFF_BIT = 4;
  localparam int unsigned RXREQ_BIT  = 5;
  localparam int unsigned TXREQ_BIT  = 6;

  // Strobes from the control sequencer to the register datapath
  typedef struct packed {
    logic clkStart;
    logic clkStop;
    logic statClear;
  } ctlStrobe_t;
endpackage

// File: rtl/cardhost_irqclk_ctrl.sv
module cardhost_irqclk_ctrl
  import cardhost_irqclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clkCmdWe,
  input  logic [1:0] clkCmdData,
  input  logic       cfgWe,
  input  logic       cfgStopTran,
  input  logic       xferDone,
  output logic       launch,
  output logic       cmdPending,
  output logic       xferActive,
  output logic       clkEnabled,
  output ctlStrobe_t strobe
);
  logic startReq, stopReq;
  logic clkEnQ, pendQ, actQ, stopTranQ, launchQ;
  logic clkEnNext, launchNext, pendNext, actNext;

  assign stopReq  = clkCmdWe & clkCmdData[0];
  assign startReq = clkCmdWe & clkCmdData[1] & ~clkCmdData[0];

  always_comb begin
    clkEnNext = clkEnQ;
    if (stopReq)       clkEnNext = 1'b0;
    else if (startReq) clkEnNext = 1'b1;

    // A configuration write sees the clock state after a same-cycle clock command
    if (cfgWe) launchNext = ~cfgStopTran & clkEnNext;
    else       launchNext = startReq & pendQ & ~stopTranQ;

    if (launchNext) pendNext = 1'b0;
    else if (cfgWe) pendNext = 1'b1;
    else            pendNext = pendQ;

    if (stopReq)                actNext = 1'b0;
    else if (launchNext)        actNext = 1'b1;
    else if (cfgWe || xferDone) actNext = 1'b0;
    else                        actNext = actQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkEnQ    <= 1'b0;
      pendQ     <= 1'b0;
      actQ      <= 1'b0;
      stopTranQ <= 1'b0;
      launchQ   <= 1'b0;
    end else begin
      clkEnQ    <= clkEnNext;
      pendQ     <= pendNext;
      actQ      <= actNext;
      launchQ   <= launchNext;
      if (cfgWe) stopTranQ <= cfgStopTran;
    end
  end

  assign strobe.clkStart  = startReq;
  assign strobe.clkStop   = stopReq;
  assign strobe.statClear = (cfgWe & ~cfgStopTran) | launchNext;

  assign launch     = launchQ;
  assign cmdPending = pendQ;
  assign xferActive = actQ;
  assign clkEnabled = clkEnQ;

  // R6: stop beats everything, aborts the transfer, never launches
  p_stop_wins_r6: assert property (@(posedge clk) disable iff (rst)
    stopReq |=> (!clkEnQ && !actQ && !launchQ));

  // R7: configuration write with stop-transfer queues without launching
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && cfgStopTran) |=> (!launchQ && pendQ && !actQ));

  // R9: a launch leaves the clock on, the transfer active and nothing pending
  p_launch_state_r9: assert property (@(posedge clk) disable iff (rst)
    launchQ |-> (clkEnQ && actQ && !pendQ));
endmodule

// File: rtl/cardhost_irqclk_dp.sv
module cardhost_irqclk_dp
  import cardhost_irqclk_pkg::*;
#(
  parameter int unsigned REQ_W     = 13,
  parameter int unsigned WR_W      = 16,
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned CLKEN_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic              maskWe,
  input  logic [WR_W-1:0]   maskData,
  input  logic [REQ_W-1:0]  evtSet,
  input  logic [REQ_W-1:0]  evtClr,
  input  logic [STAT_W-1:0] statEvt,
  input  logic              dmaEn,
  output logic [REQ_W-1:0]  reqBits,
  output logic [REQ_W-1:0]  maskBits,
  output logic [STAT_W-1:0] statBits,
  output logic              irq,
  output logic              rxDma,
  output logic              txDma
);
  localparam logic [REQ_W-1:0]  FIFO_MASK = (REQ_W'(1) << RXREQ_BIT) | (REQ_W'(1) << TXREQ_BIT);
  localparam logic [STAT_W-1:0] CLK_MASK  = STAT_W'(1) << CLKEN_BIT;

  logic [REQ_W-1:0]  reqQ, maskQ, effMask;
  logic [STAT_W-1:0] statQ;
  logic              irqQ, rxQ, txQ;
  logic              unusedMaskHi;

  assign unusedMaskHi = ^maskData[WR_W-1:REQ_W];

  for (genvar b = 0; b < REQ_W; b++) begin : g_req
    if (b == CLKOFF_BIT) begin : g_clkoff
      always_ff @(posedge clk) begin
        if (rst)                  reqQ[b] <= 1'b0;
        else if (strobe.clkStop)  reqQ[b] <= 1'b1;
        else if (strobe.clkStart) reqQ[b] <= 1'b0;
        else if (evtSet[b])       reqQ[b] <= 1'b1;
        else if (evtClr[b])       reqQ[b] <= 1'b0;
      end
    end else begin : g_event
      always_ff @(posedge clk) begin
        if (rst)            reqQ[b] <= 1'b0;
        else if (evtSet[b]) reqQ[b] <= 1'b1;
        else if (evtClr[b]) reqQ[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         maskQ <= '0;
    else if (maskWe) maskQ <= maskData[REQ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) statQ <= '0;
    else     statQ <= (strobe.statClear ? '0 : statQ) | (statEvt & ~CLK_MASK);
  end

  assign effMask = maskQ | (dmaEn ? FIFO_MASK : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irqQ <= 1'b0;
      rxQ  <= 1'b0;
      txQ  <= 1'b0;
    end else begin
      irqQ <= |(reqQ & ~effMask);
      rxQ  <= dmaEn & reqQ[RXREQ_BIT];
      txQ  <= dmaEn & reqQ[TXREQ_BIT];
    end
  end

  assign reqBits  = reqQ;
  assign maskBits = maskQ;
  assign statBits = statQ;
  assign irq      = irqQ;
  assign rxDma    = rxQ;
  assign txDma    = txQ;

  // R2: only the low request-width bits of a mask write are kept
  p_mask_width_r2: assert property (@(posedge clk) disable iff (rst)
    maskWe |=> (maskQ == $past(maskData[REQ_W-1:0])));

  // R4: with DMA on, FIFO requests alone never raise the CPU line
  p_dma_hides_fifo_r4: assert property (@(posedge clk) disable iff (rst)
    (dmaEn && ((reqQ & ~maskQ & ~FIFO_MASK) == '0)) |=> !irqQ);

  // R4: with DMA off, both DMA lines stay low
  p_dma_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !dmaEn |=> (!rxQ && !txQ));

  // R5: a start command clears the clock-off request
  p_start_clears_clkoff_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.clkStart |=> !reqQ[CLKOFF_BIT]);
endmodule

// File: rtl/cardhost_irqclk.sv
module cardhost_irqclk
  import cardhost_irqclk_pkg::*;
#(
  parameter int unsigned REQ_W     = 13,
  parameter int unsigned WR_W      = 16,
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned CLKEN_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkCmdWe,
  input  logic [1:0]        clkCmdData,
  input  logic              cfgWe,
  input  logic              cfgStopTran,
  input  logic              dmaEn,
  input  logic              maskWe,
  input  logic [WR_W-1:0]   maskData,
  input  logic [REQ_W-1:0]  evtSet,
  input  logic [REQ_W-1:0]  evtClr,
  input  logic [STAT_W-1:0] statEvt,
  input  logic              xferDone,
  output logic              irq,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              launch,
  output logic              cmdPending,
  output logic              xferActive,
  output logic [REQ_W-1:0]  reqBits,
  output logic [REQ_W-1:0]  maskBits,
  output logic [STAT_W-1:0] status
);
  ctlStrobe_t        strobe;
  logic              clkEnabled;
  logic [STAT_W-1:0] statBits;

  cardhost_irqclk_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clkCmdWe   (clkCmdWe),
    .clkCmdData (clkCmdData),
    .cfgWe      (cfgWe),
    .cfgStopTran(cfgStopTran),
    .xferDone   (xferDone),
    .launch     (launch),
    .cmdPending (cmdPending),
    .xferActive (xferActive),
    .clkEnabled (clkEnabled),
    .strobe     (strobe)
  );

  cardhost_irqclk_dp #(
    .REQ_W    (REQ_W),
    .WR_W     (WR_W),
    .STAT_W   (STAT_W),
    .CLKEN_BIT(CLKEN_BIT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .maskWe  (maskWe),
    .maskData(maskData),
    .evtSet  (evtSet),
    .evtClr  (evtClr),
    .statEvt (statEvt),
    .dmaEn   (dmaEn),
    .reqBits (reqBits),
    .maskBits(maskBits),
    .statBits(statBits),
    .irq     (irq),
    .rxDma   (rxDmaReq),
    .txDma   (txDmaReq)
  );

  assign status = statBits | (STAT_W'(clkEnabled) << CLKEN_BIT);
endmodule

// File: tb/cardhost_irqclk_tb.sv
module cardhost_irqclk_tb;
  localparam int REQ_W = 13;
  localparam int WR_W = 16;
  localparam int STAT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkCmdWe = 1'b0;
  logic [1:0] clkCmdData = '0;
  logic cfgWe = 1'b0;
  logic cfgStopTran = 1'b0;
  logic dmaEn = 1'b0;
  logic maskWe = 1'b0;
  logic [WR_W-1:0] maskData = '0;
  logic [REQ_W-1:0] evtSet = '0;
  logic [REQ_W-1:0] evtClr = '0;
  logic [STAT_W-1:0] statEvt = '0;
  logic xferDone = 1'b0;
  logic irq, rxDmaReq, txDmaReq, launch, cmdPending, xferActive;
  logic [REQ_W-1:0] reqBits, maskBits;
  logic [STAT_W-1:0] status;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cardhost_irqclk u_dut (
    .clk(clk), .rst(rst), .clkCmdWe(clkCmdWe), .clkCmdData(clkCmdData),
    .cfgWe(cfgWe), .cfgStopTran(cfgStopTran), .dmaEn(dmaEn),
    .maskWe(maskWe), .maskData(maskData), .evtSet(evtSet), .evtClr(evtClr),
    .statEvt(statEvt), .xferDone(xferDone), .irq(irq), .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq), .launch(launch), .cmdPending(cmdPending),
    .xferActive(xferActive), .reqBits(reqBits), .maskBits(maskBits),
    .status(status)
  );

  localparam int F_IRQ = 0, F_RX = 1, F_TX = 2, F_LAUNCH = 3, F_PEND = 4,
                 F_ACT = 5, F_STAT = 6, F_REQ = 7, F_MASK = 8;

  typedef struct {
    int          due;
    int          fld;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];

  function automatic logic [31:0] peek(int f);
    case (f)
      F_IRQ:    return 32'(irq);
      F_RX:     return 32'(rxDmaReq);
      F_TX:     return 32'(txDmaReq);
      F_LAUNCH: return 32'(launch);
      F_PEND:   return 32'(cmdPending);
      F_ACT:    return 32'(xferActive);
      F_STAT:   return 32'(status);
      F_REQ:    return 32'(reqBits);
      default:  return 32'(maskBits);
    endcase
  endfunction

  function automatic string fname(int f);
    case (f)
      F_IRQ:    return "irq";
      F_RX:     return "rxDmaReq";
      F_TX:     return "txDmaReq";
      F_LAUNCH: return "launch";
      F_PEND:   return "cmdPending";
      F_ACT:    return "xferActive";
      F_STAT:   return "status";
      F_REQ:    return "reqBits";
      default:  return "maskBits";
    endcase
  endfunction

  task automatic chk(int f, logic [31:0] e, string tag);
    logic [31:0] a;
    a = peek(f);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, fname(f), cyc, a, e);
    end
  endtask

  // Driver side: file an expectation due dly cycles after the current drive edge
  task automatic expect_at(int f, logic [31:0] e, int dly, string tag);
    item_t it;
    it.due = cyc + dly;
    it.fld = f;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor side: compare every item due in this cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].due == cyc) begin
          chk(sbq[i].fld, sbq[i].exp, sbq[i].tag);
          sbq.delete(i);
        end
      end
    end
  end

  task automatic fin();
    @(negedge clk);
    clkCmdWe = 1'b0; clkCmdData = '0; cfgWe = 1'b0; cfgStopTran = 1'b0;
    maskWe = 1'b0; maskData = '0; evtSet = '0; evtClr = '0; statEvt = '0;
    xferDone = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wrClk(logic [1:0] d);
    @(negedge clk); clkCmdWe = 1'b1; clkCmdData = d;
  endtask
  task automatic wrCfg(logic st);
    @(negedge clk); cfgWe = 1'b1; cfgStopTran = st;
  endtask
  task automatic wrMask(logic [WR_W-1:0] v);
    @(negedge clk); maskWe = 1'b1; maskData = v;
  endtask
  task automatic evSetClr(logic [REQ_W-1:0] s, logic [REQ_W-1:0] c);
    @(negedge clk); evtSet = s; evtClr = c;
  endtask
  task automatic stEvt(logic [STAT_W-1:0] v);
    @(negedge clk); statEvt = v;
  endtask
  task automatic setDma(logic v);
    @(negedge clk); dmaEn = v;
  endtask
  task automatic pulseDone();
    @(negedge clk); xferDone = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(F_IRQ, 0, "R1"); chk(F_RX, 0, "R1"); chk(F_TX, 0, "R1");
    chk(F_LAUNCH, 0, "R1"); chk(F_PEND, 0, "R1"); chk(F_ACT, 0, "R1");
    chk(F_STAT, 0, "R1"); chk(F_REQ, 0, "R1"); chk(F_MASK, 0, "R1");

    // R2: mask width
    wrMask(16'hFFFF); expect_at(F_MASK, 32'h1FFF, 1, "R2"); fin();
    wrMask(16'h0000); expect_at(F_MASK, 32'h0, 1, "R2"); fin();

    // R3: interrupt follows request and mask
    evSetClr(13'h004, 13'h0);
    expect_at(F_REQ, 32'h004, 1, "R3"); expect_at(F_IRQ, 0, 1, "R3");
    expect_at(F_IRQ, 1, 2, "R3"); fin();
    wrMask(16'h0004); expect_at(F_IRQ, 1, 1, "R3"); expect_at(F_IRQ, 0, 2, "R3"); fin();
    wrMask(16'h0000); expect_at(F_IRQ, 1, 2, "R3"); fin();
    evSetClr(13'h0, 13'h004); expect_at(F_REQ, 0, 1, "R3"); expect_at(F_IRQ, 0, 2, "R3"); fin();

    // R11: set wins over clear
    evSetClr(13'h008, 13'h008); expect_at(F_REQ, 32'h008, 1, "R11"); fin();
    evSetClr(13'h0, 13'h008); expect_at(F_REQ, 0, 1, "R11"); fin();

    // R4: DMA routing
    evSetClr(13'h020, 13'h0); expect_at(F_IRQ, 1, 2, "R4"); expect_at(F_RX, 0, 2, "R4"); fin();
    setDma(1'b1);
    expect_at(F_IRQ, 0, 1, "R4"); expect_at(F_RX, 1, 1, "R4"); expect_at(F_TX, 0, 1, "R4"); fin();
    evSetClr(13'h040, 13'h0); expect_at(F_TX, 1, 2, "R4"); expect_at(F_IRQ, 0, 2, "R4"); fin();
    setDma(1'b0);
    expect_at(F_IRQ, 1, 1, "R4"); expect_at(F_RX, 0, 1, "R4"); expect_at(F_TX, 0, 1, "R4"); fin();
    evSetClr(13'h0, 13'h060); expect_at(F_REQ, 0, 1, "R4"); expect_at(F_IRQ, 0, 2, "R4"); fin();

    // R5: start clock
    evSetClr(13'h010, 13'h0); expect_at(F_REQ, 32'h010, 1, "R5"); expect_at(F_IRQ, 1, 2, "R5"); fin();
    wrClk(2'b10);
    expect_at(F_STAT, 32'h100, 1, "R5"); expect_at(F_REQ, 0, 1, "R5");
    expect_at(F_LAUNCH, 0, 1, "R5"); expect_at(F_IRQ, 0, 2, "R5"); fin();

    // R6: stop clock
    wrClk(2'b01);
    expect_at(F_STAT, 0, 1, "R6"); expect_at(F_REQ, 32'h010, 1, "R6");
    expect_at(F_ACT, 0, 1, "R6"); expect_at(F_IRQ, 1, 2, "R6"); fin();

    // R7 / R8: configuration writes with the clock off
    stEvt(16'h0003); expect_at(F_STAT, 32'h0003, 1, "R7"); fin();
    wrCfg(1'b1);
    expect_at(F_PEND, 1, 1, "R7"); expect_at(F_STAT, 32'h0003, 1, "R7");
    expect_at(F_LAUNCH, 0, 1, "R7"); expect_at(F_ACT, 0, 1, "R7"); fin();
    wrCfg(1'b0);
    expect_at(F_STAT, 0, 1, "R8"); expect_at(F_PEND, 1, 1, "R8"); expect_at(F_LAUNCH, 0, 1, "R8"); fin();

    // R9 / R10: start launches the pending command
    stEvt(16'h0004); expect_at(F_STAT, 32'h0004, 1, "R9"); fin();
    wrClk(2'b10);
    expect_at(F_LAUNCH, 1, 1, "R9"); expect_at(F_PEND, 0, 1, "R9"); expect_at(F_ACT, 1, 1, "R9");
    expect_at(F_STAT, 32'h100, 1, "R9"); expect_at(F_REQ, 0, 1, "R9");
    expect_at(F_LAUNCH, 0, 2, "R10"); fin();
    pulseDone(); expect_at(F_ACT, 0, 1, "R10"); fin();

    // R8: immediate launch with the clock running
    wrCfg(1'b0);
    expect_at(F_LAUNCH, 1, 1, "R8"); expect_at(F_ACT, 1, 1, "R8"); expect_at(F_PEND, 0, 1, "R8");
    expect_at(F_LAUNCH, 0, 2, "R10"); fin();
    wrClk(2'b01); expect_at(F_ACT, 0, 1, "R6"); expect_at(F_STAT, 0, 1, "R6"); fin();

    // R9: stored stop-transfer blocks the launch
    wrCfg(1'b1); expect_at(F_PEND, 1, 1, "R9"); fin();
    wrClk(2'b10);
    expect_at(F_LAUNCH, 0, 1, "R9"); expect_at(F_PEND, 1, 1, "R9"); expect_at(F_STAT, 32'h100, 1, "R9"); fin();
    wrClk(2'b01); expect_at(F_STAT, 0, 1, "R6"); fin();

    // R6: stop and start together, stop wins
    wrCfg(1'b0); expect_at(F_PEND, 1, 1, "R8"); expect_at(F_LAUNCH, 0, 1, "R8"); fin();
    wrClk(2'b11);
    expect_at(F_LAUNCH, 0, 1, "R6"); expect_at(F_STAT, 0, 1, "R6");
    expect_at(F_REQ, 32'h010, 1, "R6"); expect_at(F_PEND, 1, 1, "R6"); fin();

    // R7: configuration write aborts an active transfer
    wrClk(2'b10); expect_at(F_LAUNCH, 1, 1, "R9"); expect_at(F_ACT, 1, 1, "R9"); expect_at(F_REQ, 0, 1, "R5"); fin();
    wrCfg(1'b1);
    expect_at(F_ACT, 0, 1, "R7"); expect_at(F_PEND, 1, 1, "R7");
    expect_at(F_LAUNCH, 0, 1, "R7"); expect_at(F_STAT, 32'h100, 1, "R7"); fin();

    repeat (4) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: actual %0d expected 0 items left", sbq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule